// File: doc/BRIEF.md
# DMA Address Protection Filter

This block sits in front of a graphics DMA path and screens every request address against one protection control register. Four memory areas are guarded: two adjacent 128 MB main-memory regions, a 512 KB on-chip work RAM and a small extra memory region. Protection in each main region and in the extra region is set by a cutoff count. The protected window begins below the region's fixed top address, drops by one step for each count, and runs up to that top. The main regions use 8 MB steps and the extra region uses 1 MB steps. The work RAM is either fully blocked or fully open.

A request presented with `req_valid_i` is judged against the configuration held at that clock edge. One cycle later it appears either as an allowed pass (`pass_valid_o` with the address on `pass_addr_o`) or as a denial (`deny_o`). A denial also sets a sticky violation flag. Software reads that flag through the status register and clears it by writing that register.

Both registers share one port. `reg_sel_i` = 0 selects the control register and `reg_sel_i` = 1 selects the status register. Control field layout: [3:0] main region 0 cutoff, [7:4] main region 1 cutoff, [8] work RAM block, [10:9] extra region cutoff. Status layout: [0] sticky violation.

Top module: `dma_prot_filter`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, and every request address is allowed.
- R2: Control bits [31:11] always read 0, and writes to them have no effect; writing 0xFFFFFFFF reads back 0x000007FF.
- R3: With cutoff a = ctrl[3:0] nonzero, addresses from 0x28000000 − a·0x800000 up to 0x27FFFFFF are denied. With a = 0, main region 0 (0x20000000..0x27FFFFFF) is open.
- R4: With cutoff b = ctrl[7:4] nonzero, addresses from 0x30000000 − b·0x800000 up to 0x2FFFFFFF are denied. With b = 0, main region 1 (0x28000000..0x2FFFFFFF) is open apart from R5.
- R5: When ctrl[3:0] is nonzero, addresses 0x28000000..0x287FFFFF are also denied.
- R6: ctrl[8] = 1 denies the whole work RAM 0x1FF80000..0x1FFFFFFF. ctrl[8] = 0 leaves the work RAM open.
- R7: With cutoff q = ctrl[10:9] nonzero, addresses from 0x1F400000 − q·0x100000 up to 0x1F3FFFFF are denied.
- R8: All protections act together. An address is denied when any one of R3..R7 denies it, including the case where both main cutoffs are nonzero.
- R9: A request at clock edge t produces exactly one of `pass_valid_o` or `deny_o` during the cycle after t. `pass_addr_o` carries the request address in that cycle. With no request, neither output is high.
- R10: A denial sets the status bit [0], and the bit stays set until the status register is written. If a clearing write and a denial occur in the same cycle, the bit stays set.
- R11: Addresses outside every protected window are allowed for every configuration, for example 0x00000000, 0x1F3FFFFF-adjacent space below the extra window, 0x30000000 and 0xFFFFFFFF.
- R12: A control write takes effect for requests presented at later edges. A request at the same edge as the write is judged with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| req_valid_i | input | 1 | DMA request valid |
| req_addr_i | input | 32 | DMA request address |
| pass_valid_o | output | 1 | Registered: previous request allowed |
| pass_addr_o | output | 32 | Registered address of the previous request |
| deny_o | output | 1 | Registered: previous request denied |

## Verification
The bench builds the block with its default region parameters, which are the real 32-bit address map, because every cutoff field is small enough to enumerate. All 256 pairs of main-region cutoffs are swept, and every pair is probed just below and just at each computed window edge and at both ends of the 8 MB lock. This brings the R5 coupling and the combination of both cutoffs within reach. The work RAM bit and all four extra-region cutoffs are swept together at their boundaries. Directed sequences cover the status flag when a set and a clear coincide, and a control write landing on the same edge as a request.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned MAIN_CW   = 4;
  localparam int unsigned EXT_CW    = 2;
  localparam int unsigned NUM_MAIN  = 2;
  localparam int unsigned CFG_W     = NUM_MAIN * MAIN_CW + 1 + EXT_CW;
  localparam int unsigned WRAM_BIT  = NUM_MAIN * MAIN_CW;
  localparam int unsigned EXT_LSB   = WRAM_BIT + 1;

  typedef struct packed {
    logic [EXT_CW-1:0]  ext_cut;
    logic               wram_blk;
    logic [MAIN_CW-1:0] main1_cut;
    logic [MAIN_CW-1:0] main0_cut;
  } prot_cfg_t;
endpackage

// File: rtl/dmaf_cutoff_win.sv
module dmaf_cutoff_win #(
  parameter int unsigned        ADDR_W = 32,
  parameter int unsigned        CUT_W  = 4,
  parameter logic [ADDR_W-1:0]  TOP    = '0,
  parameter logic [ADDR_W-1:0]  STEP   = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CUT_W-1:0]  cut_i,
  output logic              hit_o
);
  localparam int unsigned XW = ADDR_W + 1;
  localparam logic [XW-1:0] TOP_X  = {1'b0, TOP};
  localparam logic [XW-1:0] STEP_X = {1'b0, STEP};

  logic [XW-1:0] lower_x;
  logic [XW-1:0] addr_x;

  // window grows down from TOP by cut steps
  assign lower_x = TOP_X - ({{(XW-CUT_W){1'b0}}, cut_i} * STEP_X);
  assign addr_x  = {1'b0, addr_i};
  assign hit_o   = (cut_i != '0) && (addr_x >= lower_x) && (addr_x < TOP_X);
endmodule

// File: rtl/dmaf_fixed_win.sv
module dmaf_fixed_win #(
  parameter int unsigned       ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LO     = '0,
  parameter logic [ADDR_W:0]   HI     = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr_i};
  // HI is exclusive and one bit wider so a window may end at the top of space
  assign hit_o  = en_i && (addr_i >= LO) && (addr_x < HI);
endmodule

// File: rtl/dmaf_range_chk.sv
module dmaf_range_chk
  import dmaf_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] MAIN_TOP0 = 32'h2800_0000,
  parameter logic [ADDR_W-1:0] MAIN_SPAN = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] MAIN_STEP = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] WRAM_LO   = 32'h1FF8_0000,
  parameter logic [ADDR_W-1:0] WRAM_HI   = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] EXT_TOP   = 32'h1F40_0000,
  parameter logic [ADDR_W-1:0] EXT_STEP  = 32'h0010_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  prot_cfg_t         cfg_i,
  output logic              deny_o
);
  logic [MAIN_CW-1:0]  main_cut [NUM_MAIN];
  logic [NUM_MAIN-1:0] main_hit;
  logic                lock_hit;
  logic                wram_hit;
  logic                ext_hit;

  assign main_cut[0] = cfg_i.main0_cut;
  assign main_cut[1] = cfg_i.main1_cut;

  for (genvar g = 0; g < NUM_MAIN; g++) begin : g_main
    localparam logic [ADDR_W-1:0] TOP_G = MAIN_TOP0 + ADDR_W'(g) * MAIN_SPAN;
    dmaf_cutoff_win #(
      .ADDR_W(ADDR_W), .CUT_W(MAIN_CW), .TOP(TOP_G), .STEP(MAIN_STEP)
    ) u_win (
      .addr_i(addr_i), .cut_i(main_cut[g]), .hit_o(main_hit[g])
    );
  end

  // any region-0 cutoff also seals the first step of region 1
  dmaf_fixed_win #(
    .ADDR_W(ADDR_W), .LO(MAIN_TOP0), .HI({1'b0, MAIN_TOP0} + {1'b0, MAIN_STEP})
  ) u_lock (
    .addr_i(addr_i), .en_i(cfg_i.main0_cut != '0), .hit_o(lock_hit)
  );

  dmaf_fixed_win #(
    .ADDR_W(ADDR_W), .LO(WRAM_LO), .HI({1'b0, WRAM_HI})
  ) u_wram (
    .addr_i(addr_i), .en_i(cfg_i.wram_blk), .hit_o(wram_hit)
  );

  dmaf_cutoff_win #(
    .ADDR_W(ADDR_W), .CUT_W(EXT_CW), .TOP(EXT_TOP), .STEP(EXT_STEP)
  ) u_ext (
    .addr_i(addr_i), .cut_i(cfg_i.ext_cut), .hit_o(ext_hit)
  );

  assign deny_o = (|main_hit) | lock_hit | wram_hit | ext_hit;
endmodule

// File: rtl/dmaf_regs.sv
module dmaf_regs
  import dmaf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             viol_set_i,
  output prot_cfg_t        cfg_o,
  output logic             viol_o,
  output logic [REG_W-1:0] rdata_o
);
  prot_cfg_t cfg_q;
  logic      viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && !sel_i) begin
      cfg_q <= prot_cfg_t'(wdata_i);
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
    end else if (viol_set_i) begin
      viol_q <= 1'b1;
    end else if (we_i && sel_i) begin
      viol_q <= 1'b0;
    end
  end

  always_comb begin
    if (sel_i) rdata_o = {{(REG_W-1){1'b0}}, viol_q};
    else       rdata_o = {{(REG_W-CFG_W){1'b0}}, cfg_q};
  end

  assign cfg_o  = cfg_q;
  assign viol_o = viol_q;
endmodule

// File: rtl/dma_prot_filter.sv
module dma_prot_filter
  import dmaf_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] MAIN_TOP0 = 32'h2800_0000,
  parameter logic [ADDR_W-1:0] MAIN_SPAN = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] MAIN_STEP = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] WRAM_LO   = 32'h1FF8_0000,
  parameter logic [ADDR_W-1:0] WRAM_HI   = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] EXT_TOP   = 32'h1F40_0000,
  parameter logic [ADDR_W-1:0] EXT_STEP  = 32'h0010_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              pass_valid_o,
  output logic [ADDR_W-1:0] pass_addr_o,
  output logic              deny_o
);
  prot_cfg_t         cfg_q;
  logic              viol_q;
  logic              hit;
  logic              vld_q;
  logic              hit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[REG_W-1:CFG_W];

  dmaf_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i[CFG_W-1:0]),
    .viol_set_i (req_valid_i & hit),
    .cfg_o      (cfg_q),
    .viol_o     (viol_q),
    .rdata_o    (reg_rdata_o)
  );

  dmaf_range_chk #(
    .ADDR_W(ADDR_W), .MAIN_TOP0(MAIN_TOP0), .MAIN_SPAN(MAIN_SPAN),
    .MAIN_STEP(MAIN_STEP), .WRAM_LO(WRAM_LO), .WRAM_HI(WRAM_HI),
    .EXT_TOP(EXT_TOP), .EXT_STEP(EXT_STEP)
  ) u_chk (
    .addr_i (req_addr_i),
    .cfg_i  (cfg_q),
    .deny_o (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= req_valid_i;
      hit_q <= hit;
      if (req_valid_i) addr_q <= req_addr_i;
    end
  end

  assign pass_valid_o = vld_q & ~hit_q;
  assign deny_o       = vld_q & hit_q;
  assign pass_addr_o  = addr_q;
endmodule

// File: rtl/dmaf_sva.sv
module dmaf_sva
  import dmaf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_sel_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              pass_valid_o,
  input logic              deny_o,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              viol_q
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  a_r1_reset_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> (cfg_q == '0 && !viol_q));

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_o[REG_W-1:CFG_W] == '0));

  a_r9_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> ((pass_valid_o | deny_o) == $past(req_valid_i)));

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_valid_o && deny_o));

  a_r6_wram_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(req_valid_i && cfg_q[WRAM_BIT] &&
                   req_addr_i >= 32'h1FF8_0000 && req_addr_i <= 32'h1FFF_FFFF))
    |-> deny_o);

  a_r10_set_on_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> viol_q);

  a_r10_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !(reg_we_i && reg_sel_i)) |=> viol_q);
endmodule

bind dma_prot_filter dmaf_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_sel_i    (reg_sel_i),
  .reg_rdata_o  (reg_rdata_o),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .pass_valid_o (pass_valid_o),
  .deny_o       (deny_o),
  .cfg_q        (cfg_q),
  .viol_q       (viol_q)
);

// File: tb/dma_prot_filter_bench.sv
module dma_prot_filter_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        pass_valid;
  logic [31:0] pass_addr;
  logic        deny;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prot_filter u_dma_prot_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .pass_valid_o(pass_valid), .pass_addr_o(pass_addr), .deny_o(deny)
  );

  function automatic bit exp_deny(input logic [10:0] c, input logic [31:0] a);
    longint unsigned x  = longint'(a);
    longint unsigned ca = longint'(c[3:0]);
    longint unsigned cb = longint'(c[7:4]);
    longint unsigned cq = longint'(c[10:9]);
    bit d = 1'b0;
    if (ca != 0 && x >= 64'h2800_0000 - ca*64'h80_0000 && x < 64'h2800_0000) d = 1'b1;
    if (cb != 0 && x >= 64'h3000_0000 - cb*64'h80_0000 && x < 64'h3000_0000) d = 1'b1;
    if (ca != 0 && x >= 64'h2800_0000 && x < 64'h2880_0000) d = 1'b1;
    if (c[8] && x >= 64'h1FF8_0000 && x < 64'h2000_0000) d = 1'b1;
    if (cq != 0 && x >= 64'h1F40_0000 - cq*64'h10_0000 && x < 64'h1F40_0000) d = 1'b1;
    return d;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic probe(input logic [31:0] a, input bit exp_d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(deny == exp_d && pass_valid == !exp_d && pass_addr == a, tag,
          {deny, pass_valid, pass_addr[29:0]}, {exp_d, !exp_d, a[29:0]});
  endtask

  task automatic probe_m(input logic [10:0] c, input logic [31:0] a, input string tag);
    probe(a, exp_deny(c, a), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_check(1'b0, 32'h0, "R1 ctrl reset");
    rd_check(1'b1, 32'h0, "R1 status reset");
    probe(32'h2000_0000, 1'b0, "R1 open main0");
    probe(32'h2FFF_FFFF, 1'b0, "R1 open main1");
    probe(32'h1FF8_0000, 1'b0, "R1 open wram");
    probe(32'h1F3F_FFFF, 1'b0, "R1 open ext");

    // R9 idle: no request, no result
    @(negedge clk);
    check(!pass_valid && !deny, "R9 idle", {pass_valid, deny}, 0);

    // R2 upper bits
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_check(1'b0, 32'h0000_07FF, "R2 readback");
    wr_reg(1'b0, 32'hFFFF_F800);
    rd_check(1'b0, 32'h0, "R2 upper only");

    // R3 R4 R5 R8 sweep of both main cutoffs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [10:0] c;
        logic [31:0] la, lb;
        c  = {3'b000, 4'(b), 4'(a)};
        la = 32'h2800_0000 - 32'(a) * 32'h80_0000;
        lb = 32'h3000_0000 - 32'(b) * 32'h80_0000;
        wr_reg(1'b0, {21'h0, c});
        probe_m(c, la - 1, "R3 below main0 edge");
        probe_m(c, la,     "R3 at main0 edge");
        probe_m(c, 32'h27FF_FFFF, "R3 main0 top");
        probe_m(c, 32'h2800_0000, "R5 lock low");
        probe_m(c, 32'h287F_FFFF, "R5 lock high");
        probe_m(c, 32'h2880_0000, "R5 above lock");
        probe_m(c, lb - 1, "R4 below main1 edge");
        probe_m(c, lb,     "R4 at main1 edge");
        probe_m(c, 32'h2FFF_FFFF, "R8 main1 top");
        probe_m(c, 32'h3000_0000, "R11 above main1");
      end
    end

    // R6 R7 sweep with main cutoffs set
    for (int q = 0; q < 4; q++) begin
      for (int w = 0; w < 2; w++) begin
        logic [10:0] c;
        logic [31:0] le;
        c  = {2'(q), 1'(w), 4'h3, 4'h5};
        le = 32'h1F40_0000 - 32'(q) * 32'h10_0000;
        wr_reg(1'b0, {21'h0, c});
        probe_m(c, le - 1, "R7 below ext edge");
        probe_m(c, le,     "R7 at ext edge");
        probe_m(c, 32'h1F3F_FFFF, "R7 ext top");
        probe_m(c, 32'h1F40_0000, "R11 above ext");
        probe_m(c, 32'h1FF7_FFFF, "R6 below wram");
        probe_m(c, 32'h1FF8_0000, "R6 wram low");
        probe_m(c, 32'h1FFF_FFFF, "R6 wram high");
        probe_m(c, 32'h2000_0000, "R8 main0 base");
        probe_m(c, 32'h0000_0000, "R11 zero");
        probe_m(c, 32'hFFFF_FFFF, "R11 top of space");
      end
    end

    // R10 sticky flag
    wr_reg(1'b1, 32'h0);
    rd_check(1'b1, 32'h0, "R10 cleared");
    wr_reg(1'b0, 32'h0000_0100);
    probe(32'h1FF8_0040, 1'b1, "R10 deny");
    rd_check(1'b1, 32'h1, "R10 set");
    probe(32'h0000_1000, 1'b0, "R10 allow");
    rd_check(1'b1, 32'h1, "R10 held");
    wr_reg(1'b1, 32'h0);
    rd_check(1'b1, 32'h0, "R10 write clears");
    // clear and set at the same edge
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b1; req_valid = 1'b1; req_addr = 32'h1FFC_0000;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    check(deny == 1'b1, "R10 coincident deny", deny, 1);
    rd_check(1'b1, 32'h1, "R10 set wins");
    wr_reg(1'b1, 32'h0);

    // R12 write and request on the same edge
    wr_reg(1'b0, 32'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_0100;
    req_valid = 1'b1; req_addr = 32'h1FF8_0000;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    check(pass_valid && !deny, "R12 old cfg used", {pass_valid, deny}, 2'b10);
    probe(32'h1FF8_0000, 1'b1, "R12 new cfg used");

    // R9 back-to-back requests
    wr_reg(1'b0, 32'h0000_0001);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h27FF_FFF0;
    @(negedge clk);
    req_addr = 32'h1000_0000;
    check(deny && !pass_valid, "R9 b2b first", {deny, pass_valid}, 2'b10);
    @(negedge clk);
    req_valid = 1'b0;
    check(pass_valid && !deny && pass_addr == 32'h1000_0000, "R9 b2b second",
          pass_addr, 32'h1000_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule